// File: doc/BRIEF.md
# Three-Share Masked ARX Datapath

This block performs the three primitive operations of add-rotate-xor ciphers on data that never appears in plain form on any wire. Each operand enters as three Boolean shares whose XOR is the true value. The result leaves in the same three-share form, and the consumer recombines it only where that is allowed. XOR and rotation are linear, so they act on each share on its own. Addition modulo 2^WIDTH is nonlinear. It is built as a ripple carry chain in which every AND is a three-share threshold gate, and a register stage follows every carry layer. Fresh random bits from an input port re-mask each carry so that the sharing stays uniform.

A request carries an operation code, a rotate amount, two shared operands and the handshake bit `in_valid`. Every operation takes the same fixed pipeline depth of WIDTH stages, so results return in request order. The output side uses a valid/ready handshake. While a result is held back, the whole pipeline freezes and `in_ready` goes low.

Top module: `masked_arx_unit`

## Requirements
- R1: With operation code 0 (add), the XOR of the three result shares equals (A + B) mod 2^WIDTH. Here A and B are the XORs of the respective input shares.
- R2: With operation code 1 (xor), the recombined result equals A XOR B.
- R3: With operation code 2 (rotate), the recombined result equals A rotated left by `in_rot` positions, for every amount from 0 to WIDTH-1. The B shares have no effect on this result.
- R4: When `out_ready` stays high, a request accepted on a clock edge shows up as a valid result exactly WIDTH cycles later. Results come out in acceptance order and none is lost.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle the output shares and `out_valid` are unchanged.
- R6: During reset and after it, until a request has passed the pipeline, `out_valid` is low and `in_ready` is high.
- R7: For the linear operations (codes 1, 2 and 3), result share j is computed from input shares of index j alone: a_j XOR b_j, rotl(a_j), or a_j.
- R8: The addition result is correct for any value on the random port, including all zeros and all ones. Stage k consumes bits 2k+1 and 2k of `rnd`.
- R9: With operation code 3 (pass), the result shares equal the A shares unchanged.
- R10: In the addition, each carry share depends on only two of the three share indices of its inputs. The XOR of the carry shares equals the majority of the recombined operand bits and the incoming carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when in_valid is high |
| in_op | input | 2 | 0 add, 1 xor, 2 rotate left, 3 pass A |
| in_rot | input | ROT_W | Rotate amount |
| in_a0 | input | WIDTH | Operand A, share 0 |
| in_a1 | input | WIDTH | Operand A, share 1 |
| in_a2 | input | WIDTH | Operand A, share 2 |
| in_b0 | input | WIDTH | Operand B, share 0 |
| in_b1 | input | WIDTH | Operand B, share 1 |
| in_b2 | input | WIDTH | Operand B, share 2 |
| rnd | input | 2*WIDTH | Fresh random bits, two per carry stage per cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_r0 | output | WIDTH | Result share 0 |
| out_r1 | output | WIDTH | Result share 1 |
| out_r2 | output | WIDTH | Result share 2 |

## Verification
Every result, whatever its operation, is due WIDTH cycles after the edge that accepted it, plus one cycle for each edge on which the output was held. The bench samples between edges. It stamps each accepted request with the cycle number and the running count of held cycles. On each delivery it checks the delay only when no hold occurred, and in every case it checks order and value against a queue of results it predicts itself. The cycle that follows every held cycle is checked for frozen outputs and a low `in_ready`.

// File: rtl/arx_mask_pkg.sv
package arx_mask_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XOR  = 2'd1,
    OP_ROTL = 2'd2,
    OP_PASS = 2'd3
  } arx_op_e;

  // Three-share threshold AND: output share i uses input shares i+1 and i+2 only.
  function automatic logic [2:0] ti_and3(input logic [2:0] x, input logic [2:0] y);
    logic [2:0] z;
    z[0] = (x[1] & y[1]) ^ (x[1] & y[2]) ^ (x[2] & y[1]);
    z[1] = (x[2] & y[2]) ^ (x[2] & y[0]) ^ (x[0] & y[2]);
    z[2] = (x[0] & y[0]) ^ (x[0] & y[1]) ^ (x[1] & y[0]);
    return z;
  endfunction

endpackage

// File: rtl/masked_lin_unit.sv
module masked_lin_unit
  import arx_mask_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int ROT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  arx_op_e                 op_i,
  input  logic [ROT_W-1:0]        rot_i,
  input  logic [2:0][WIDTH-1:0]   a_i,
  input  logic [2:0][WIDTH-1:0]   b_i,
  output logic [2:0][WIDTH-1:0]   res_o
);

  // Each share is processed alone; nothing crosses share indices.
  for (genvar j = 0; j < 3; j++) begin : g_share
    logic [2*WIDTH-1:0] dbl;
    logic [WIDTH-1:0]   rotated;

    assign dbl     = {a_i[j], a_i[j]} << rot_i;
    assign rotated = dbl[2*WIDTH-1:WIDTH];

    always_comb begin
      unique case (op_i)
        OP_ADD:  res_o[j] = '0;
        OP_XOR:  res_o[j] = a_i[j] ^ b_i[j];
        OP_ROTL: res_o[j] = rotated;
        default: res_o[j] = a_i[j];
      endcase
    end
  end

endmodule

// File: rtl/masked_carry_cell.sv
module masked_carry_cell
  import arx_mask_pkg::*;
(
  input  logic [2:0] a_i,
  input  logic [2:0] b_i,
  input  logic [2:0] c_i,
  input  logic [1:0] rnd_i,
  output logic [2:0] sum_o,
  output logic [2:0] carry_o
);

  logic [2:0] prop;
  logic [2:0] gen_sh;
  logic [2:0] pc_sh;
  logic [2:0] raw;

  always_comb begin
    prop   = a_i ^ b_i;
    sum_o  = prop ^ c_i;
    gen_sh = ti_and3(a_i, b_i);
    pc_sh  = ti_and3(prop, c_i);
    raw    = gen_sh ^ pc_sh;
    // re-mask with two fresh bits; their XOR over all shares cancels
    carry_o[0] = raw[0] ^ rnd_i[0];
    carry_o[1] = raw[1] ^ rnd_i[1];
    carry_o[2] = raw[2] ^ rnd_i[0] ^ rnd_i[1];
  end

endmodule

// File: rtl/masked_add_stage.sv
module masked_add_stage
  import arx_mask_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic [1:0]            rnd_i,
  input  logic                  vld_i,
  input  arx_op_e               op_i,
  input  logic [2:0][WIDTH-1:0] a_i,
  input  logic [2:0][WIDTH-1:0] b_i,
  input  logic [2:0][WIDTH-1:0] r_i,
  input  logic [2:0]            c_i,
  output logic                  vld_q,
  output arx_op_e               op_q,
  output logic [2:0][WIDTH-1:0] a_q,
  output logic [2:0][WIDTH-1:0] b_q,
  output logic [2:0][WIDTH-1:0] r_q,
  output logic [2:0]            c_q
);

  logic [2:0]            a_bit, b_bit;
  logic [2:0]            sum_sh, carry_sh;
  logic [2:0][WIDTH-1:0] r_d;

  always_comb begin
    for (int j = 0; j < 3; j++) begin
      a_bit[j] = a_i[j][BIT];
      b_bit[j] = b_i[j][BIT];
    end
  end

  masked_carry_cell u_cell (
    .a_i     (a_bit),
    .b_i     (b_bit),
    .c_i     (c_i),
    .rnd_i   (rnd_i),
    .sum_o   (sum_sh),
    .carry_o (carry_sh)
  );

  always_comb begin
    r_d = r_i;
    if (op_i == OP_ADD) begin
      for (int j = 0; j < 3; j++) r_d[j][BIT] = sum_sh[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= OP_ADD;
      a_q   <= '0;
      b_q   <= '0;
      r_q   <= '0;
      c_q   <= '0;
    end else if (adv) begin
      vld_q <= vld_i;
      op_q  <= op_i;
      a_q   <= a_i;
      b_q   <= b_i;
      r_q   <= r_d;
      c_q   <= carry_sh;
    end
  end

  // recombined views, used only by the checks below
  logic a_plain, b_plain, c_plain, cn_plain, s_plain;
  assign a_plain  = ^a_bit;
  assign b_plain  = ^b_bit;
  assign c_plain  = ^c_i;
  assign cn_plain = ^carry_sh;
  assign s_plain  = ^sum_sh;

  a_r10_carry_majority: assert property (@(posedge clk) disable iff (rst_n !== 1'b1)
    (vld_i && op_i == OP_ADD) |->
      cn_plain == ((a_plain & b_plain) | (a_plain & c_plain) | (b_plain & c_plain)));

  a_r1_sum_bit: assert property (@(posedge clk) disable iff (rst_n !== 1'b1)
    (vld_i && op_i == OP_ADD) |-> s_plain == (a_plain ^ b_plain ^ c_plain));

  a_r5_stage_hold: assert property (@(posedge clk) disable iff (rst_n !== 1'b1)
    !adv |=> ($stable(vld_q) && $stable(r_q) && $stable(c_q)));

endmodule

// File: rtl/masked_arx_unit.sv
module masked_arx_unit
  import arx_mask_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int ROT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int RND_W = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [ROT_W-1:0] in_rot,
  input  logic [WIDTH-1:0] in_a0,
  input  logic [WIDTH-1:0] in_a1,
  input  logic [WIDTH-1:0] in_a2,
  input  logic [WIDTH-1:0] in_b0,
  input  logic [WIDTH-1:0] in_b1,
  input  logic [WIDTH-1:0] in_b2,
  input  logic [RND_W-1:0] rnd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_r0,
  output logic [WIDTH-1:0] out_r1,
  output logic [WIDTH-1:0] out_r2
);

  typedef logic [2:0][WIDTH-1:0] shares_t;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync = rst_sync_q[1];

  // one global clock enable: the chain moves unless a result is held
  logic adv;
  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  shares_t a_sh, b_sh, lin_res;
  arx_op_e op_in;
  assign a_sh  = {in_a2, in_a1, in_a0};
  assign b_sh  = {in_b2, in_b1, in_b0};
  assign op_in = arx_op_e'(in_op);

  masked_lin_unit #(.WIDTH(WIDTH)) u_lin (
    .op_i  (op_in),
    .rot_i (in_rot),
    .a_i   (a_sh),
    .b_i   (b_sh),
    .res_o (lin_res)
  );

  logic       st_v  [WIDTH+1];
  arx_op_e    st_op [WIDTH+1];
  shares_t    st_a  [WIDTH+1];
  shares_t    st_b  [WIDTH+1];
  shares_t    st_r  [WIDTH+1];
  logic [2:0] st_c  [WIDTH+1];

  assign st_v[0]  = in_valid;
  assign st_op[0] = op_in;
  assign st_a[0]  = a_sh;
  assign st_b[0]  = b_sh;
  assign st_r[0]  = lin_res;
  assign st_c[0]  = 3'b000;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    masked_add_stage #(.WIDTH(WIDTH), .BIT(k)) u_stage (
      .clk   (clk),
      .rst_n (rst_sync),
      .adv   (adv),
      .rnd_i (rnd[2*k +: 2]),
      .vld_i (st_v[k]),
      .op_i  (st_op[k]),
      .a_i   (st_a[k]),
      .b_i   (st_b[k]),
      .r_i   (st_r[k]),
      .c_i   (st_c[k]),
      .vld_q (st_v[k+1]),
      .op_q  (st_op[k+1]),
      .a_q   (st_a[k+1]),
      .b_q   (st_b[k+1]),
      .r_q   (st_r[k+1]),
      .c_q   (st_c[k+1])
    );
  end

  assign out_valid = st_v[WIDTH];
  assign out_r0    = st_r[WIDTH][0];
  assign out_r1    = st_r[WIDTH][1];
  assign out_r2    = st_r[WIDTH][2];

  // checks on the linear path, in recombined form
  logic [WIDTH-1:0]   a_plain, b_plain, lin_plain;
  logic [2*WIDTH-1:0] a_dbl;
  assign a_plain   = in_a0 ^ in_a1 ^ in_a2;
  assign b_plain   = in_b0 ^ in_b1 ^ in_b2;
  assign lin_plain = lin_res[0] ^ lin_res[1] ^ lin_res[2];
  assign a_dbl     = {a_plain, a_plain} << in_rot;

  a_r2_xor_recombines: assert property (@(posedge clk) disable iff (rst_sync !== 1'b1)
    (in_valid && op_in == OP_XOR) |-> lin_plain == (a_plain ^ b_plain));

  a_r3_rot_recombines: assert property (@(posedge clk) disable iff (rst_sync !== 1'b1)
    (in_valid && op_in == OP_ROTL) |-> lin_plain == a_dbl[2*WIDTH-1:WIDTH]);

  a_r5_out_frozen: assert property (@(posedge clk) disable iff (rst_sync !== 1'b1)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r0) && $stable(out_r1) && $stable(out_r2)));

  a_r5_no_accept_when_held: assert property (@(posedge clk) disable iff (rst_sync !== 1'b1)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_masked_arx_unit.sv
module test_masked_arx_unit;

  localparam int W     = 16;
  localparam int ROT_W = $clog2(W);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [1:0]       in_op;
  logic [ROT_W-1:0] in_rot;
  logic [W-1:0]     in_a0, in_a1, in_a2, in_b0, in_b1, in_b2;
  logic [2*W-1:0]   rnd;
  logic             out_valid;
  logic             out_ready;
  logic [W-1:0]     out_r0, out_r1, out_r2;

  always #2 clk = ~clk;  // 250 MHz

  masked_arx_unit #(.WIDTH(W)) i_masked_arx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rot(in_rot),
    .in_a0(in_a0), .in_a1(in_a1), .in_a2(in_a2),
    .in_b0(in_b0), .in_b1(in_b1), .in_b2(in_b2),
    .rnd(rnd), .out_valid(out_valid), .out_ready(out_ready),
    .out_r0(out_r0), .out_r1(out_r1), .out_r2(out_r2)
  );

  typedef struct {
    logic [1:0]       op;
    logic [W-1:0]     a0, a1, a2, b0, b1, b2;
    logic [ROT_W-1:0] rot;
    int               cyc;
    int               stalls;
  } req_t;

  req_t q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  int   cyc    = 0;
  int   stalls = 0;
  bit   mon_on = 1'b0;
  bit   stall_mode = 1'b0;
  int   rnd_mode = 0;
  bit   held = 1'b0;
  logic [3*W-1:0] held_val;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [ROT_W-1:0] r);
    if (r == 0) return x;
    return (x << r) | (x >> (W - int'(r)));
  endfunction

  function automatic logic [W-1:0] lin_share(input logic [1:0] op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic [ROT_W-1:0] r);
    case (op)
      2'd1:    return a ^ b;
      2'd2:    return rotl(a, r);
      default: return a;
    endcase
  endfunction

  // stimulus background: random bits and consumer readiness
  always @(negedge clk) begin
    case (rnd_mode)
      1:       rnd = '0;
      2:       rnd = '1;
      default: rnd = {16'($urandom), 16'($urandom)};
    endcase
    out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic monitor_step();
    req_t e;
    logic [W-1:0] av, bv, expv, got;
    cyc++;
    if (held) begin
      check(out_valid == 1'b1, "R5 valid kept", 64'(out_valid), 64'(1));
      check({out_r2, out_r1, out_r0} == held_val, "R5 shares frozen",
            64'({out_r2, out_r1, out_r0}), 64'(held_val));
    end
    held = out_valid && !out_ready;
    if (held) begin
      held_val = {out_r2, out_r1, out_r0};
      check(in_ready == 1'b0, "R5 in_ready low", 64'(in_ready), 64'(0));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected result", 64'(out_r0 ^ out_r1 ^ out_r2), 64'(0));
      end else begin
        e  = q.pop_front();
        av = e.a0 ^ e.a1 ^ e.a2;
        bv = e.b0 ^ e.b1 ^ e.b2;
        got = out_r0 ^ out_r1 ^ out_r2;
        case (e.op)
          2'd0: begin expv = av + bv;       check(got == expv, "R1/R8 add", 64'(got), 64'(expv)); end
          2'd1: begin expv = av ^ bv;       check(got == expv, "R2 xor", 64'(got), 64'(expv)); end
          2'd2: begin expv = rotl(av, e.rot); check(got == expv, "R3 rotate", 64'(got), 64'(expv)); end
          default: begin expv = av;         check(got == expv, "R9 pass", 64'(got), 64'(expv)); end
        endcase
        if (e.op != 2'd0) begin
          check(out_r0 == lin_share(e.op, e.a0, e.b0, e.rot), "R7 share0",
                64'(out_r0), 64'(lin_share(e.op, e.a0, e.b0, e.rot)));
          check(out_r1 == lin_share(e.op, e.a1, e.b1, e.rot), "R7 share1",
                64'(out_r1), 64'(lin_share(e.op, e.a1, e.b1, e.rot)));
          check(out_r2 == lin_share(e.op, e.a2, e.b2, e.rot), "R7 share2",
                64'(out_r2), 64'(lin_share(e.op, e.a2, e.b2, e.rot)));
        end
        if (e.stalls == stalls)
          check(cyc - e.cyc == W, "R4 latency", 64'(cyc - e.cyc), 64'(W));
      end
    end
    if (out_valid && !out_ready) stalls++;
    if (in_valid && in_ready) begin
      e.op = in_op; e.rot = in_rot;
      e.a0 = in_a0; e.a1 = in_a1; e.a2 = in_a2;
      e.b0 = in_b0; e.b1 = in_b1; e.b2 = in_b2;
      e.cyc = cyc; e.stalls = stalls;
      q.push_back(e);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (mon_on && !done) monitor_step();
  end

  task automatic send(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [ROT_W-1:0] r);
    logic [W-1:0] m1, m2, n1, n2;
    m1 = W'($urandom); m2 = W'($urandom);
    n1 = W'($urandom); n2 = W'($urandom);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rot = r;
    in_a0 = a ^ m1 ^ m2; in_a1 = m1; in_a2 = m2;
    in_b0 = b ^ n1 ^ n2; in_b1 = n1; in_b2 = n2;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog at cycle %0d: actual hung expected done", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_rot = '0;
    in_a0 = '0; in_a1 = '0; in_a2 = '0; in_b0 = '0; in_b1 = '0; in_b2 = '0;
    rnd = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R6 valid low in reset", 64'(out_valid), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    #1;
    check(out_valid == 1'b0, "R6 valid low after reset", 64'(out_valid), 64'(0));
    check(in_ready == 1'b1, "R6 ready high after reset", 64'(in_ready), 64'(1));

    // R8: addition corners under fixed random bits
    rnd_mode = 1;
    send(2'd0, 16'hFFFF, 16'h0001, '0);
    send(2'd0, 16'h8000, 16'h8000, '0);
    send(2'd0, 16'hFFFF, 16'hFFFF, '0);
    rnd_mode = 2;
    send(2'd0, 16'h0000, 16'h0000, '0);
    send(2'd0, 16'h1234, 16'hEDCC, '0);
    send(2'd0, 16'h7FFF, 16'h0001, '0);
    rnd_mode = 0;
    // R3 rotate bounds, R9 pass, R2 xor
    send(2'd2, 16'h8001, 16'hFFFF, '0);
    send(2'd2, 16'h8001, 16'h0000, ROT_W'(W - 1));
    send(2'd2, 16'hA5C3, 16'h1234, ROT_W'(1));
    send(2'd3, 16'hBEEF, 16'h5555, ROT_W'(3));
    send(2'd1, 16'hFFFF, 16'h0F0F, '0);
    idle();
    repeat (W + 4) @(negedge clk);

    // free-running mix, back to back (R4 latency on every result)
    for (int i = 0; i < 150; i++)
      send(2'($urandom), W'($urandom), W'($urandom), ROT_W'($urandom));
    idle();

    // random back-pressure and gaps (R5)
    stall_mode = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 3 == 0) idle();
      send(2'($urandom), W'($urandom), W'($urandom), ROT_W'($urandom));
    end
    idle();
    stall_mode = 1'b0;

    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4 all delivered", 64'(q.size()), 64'(0));
    finish_run();
  end

endmodule